// File: doc/BRIEF.md
# Asynchronous Serial Port with Automatic Bit-Rate Detection

This block is a full-duplex asynchronous serial port for 8-bit characters. Both directions are double buffered. Software can load the next outgoing character while the current one is shifting out. A received character waits in a holding register while the next one arrives. A small word-wide register interface gives access to the data path, a 16-bit rate divisor, a control word and a status word. Two interrupt lines report transmit space and receive events.

The bit rate comes from a tick generator that fires once every DIV+1 clocks. Each bit lasts 16 ticks, so a divisor of zero gives the top rate of one sixteenth of the clock. A divisor can be written directly. As an alternative, software can arm the auto-rate mode. The hardware then waits for the line to be idle, times the low start bit of a reference character (0xFF, whose data and stop bits are all high) and writes the rounded divisor itself. It then raises a done flag and leaves the mode.

Three state machines do the work. The transmitter moves through TX_IDLE -> TX_START (a tick arrives while the holding register is full) -> TX_DATA (16 ticks) -> TX_STOP (8 bits done) -> TX_IDLE (16 ticks). The receiver moves through RX_IDLE -> RX_START (line seen low on a tick) -> RX_DATA (still low at the half-bit point) or back to RX_IDLE (false start) -> RX_STOP (8 bits sampled) -> RX_IDLE (stop high) or RX_HOLD_LOW (stop low) -> RX_IDLE (line high again). The rate detector moves through AB_OFF -> AB_ARM (mode armed) -> AB_EDGE (line high) -> AB_MEASURE (line low) -> AB_OFF (line high again, divisor loaded). Clearing the mode returns the detector to AB_OFF, and the receiver is held in RX_IDLE while the mode is armed.

Top module: `autobaud_uart`

## Requirements
- R1: After reset, txd is high, both interrupts are low, the divisor reads RESET_DIV, control reads 0 and status reads 0x21.
- R2: A transmitted frame has one low start bit, 8 data bits sent LSB first and one high stop bit. Each bit lasts 16*(DIV+1) clocks.
- R3: A write to the data register (address 0) fills the transmit holding register while the shifter is busy, and both characters are sent. A data write while the holding register is full (status bit 0 = 0) is ignored.
- R4: The receiver samples each bit at its middle. A complete character sets status bit 1 and is read at address 0. That read clears status bit 1.
- R5: A low stop bit sets status bit 3 and the character is still stored. Reception resumes only after the line goes high again. Writing 1 to status bit 3 clears it.
- R6: If a character completes while status bit 1 is set, status bit 2 is set and the unread character is kept. Writing 1 to bit 2 clears it.
- R7: Transmit and receive run at the same time without affecting each other.
- R8: The divisor (address 1) reads back as written and changes the bit time of both directions. It changes only on a write or on an auto-rate load.
- R9: Setting control bit 0 (address 2) arms auto-rate detection. The low time L of the next start bit, counted in clocks, loads the divisor with round(L/16)-1. Status bit 4 is then set and control bit 0 clears. No character is received while the mode is armed. Writing 1 to status bit 4 clears it.
- R10: irq_tx equals control bit 1 AND status bit 0. irq_rx equals control bit 2 AND (status bit 1 OR status bit 4).
- R11: A divisor of 0 gives 16 clocks per bit in both directions.
- R12: Status bit 5 is 1 when the transmitter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 0 pops the receive holding register) |
| reg_addr | input | 2 | Register address: 0 data, 1 divisor, 2 control, 3 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |
| irq_tx | output | 1 | Transmit holding register empty interrupt |
| irq_rx | output | 1 | Receive or auto-rate-done interrupt |

## Verification
The bench builds the block with a 16-bit divisor, 16 ticks per bit and a reset divisor of 3. Frames are therefore 64 clocks per bit, and every transmit, receive, framing, overrun and double-buffer case fits in a few thousand cycles. The bench then writes a divisor of 0 to reach the top rate of 16 clocks per bit. It runs auto-rate detection on a 96-clock reference start bit, which must yield a divisor of 5, and then checks traffic at the detected rate in both directions.

// File: rtl/abu_pkg.sv
package abu_pkg;
    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_DIV  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD_LOW} rx_state_e;
    typedef enum logic [1:0] {AB_OFF, AB_ARM, AB_EDGE, AB_MEASURE} ab_state_e;
endpackage

// File: rtl/abu_tick_gen.sv
module abu_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // fires once every divisor+1 clocks; >= tolerates a divisor lowered mid-count
    assign tick = (cnt >= divisor);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/abu_tx.sv
module abu_tx
    import abu_pkg::*;
#(
    parameter int PH_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hold_full,
    input  logic [7:0] hold_data,
    output logic       take,
    output logic       busy,
    output logic       txd
);
    localparam logic [PH_W-1:0] PH_LAST = '1;

    tx_state_e       st, st_nx;
    logic [PH_W-1:0] ph;
    logic [2:0]      bitn;
    logic [7:0]      sh;
    logic            ph_end;

    assign take   = (st == TX_IDLE) && tick && hold_full;
    assign ph_end = tick && (ph == PH_LAST);
    assign busy   = (st != TX_IDLE);

    always_comb begin
        st_nx = st;
        unique case (st)
            TX_IDLE:  if (take) st_nx = TX_START;
            TX_START: if (ph_end) st_nx = TX_DATA;
            TX_DATA:  if (ph_end && bitn == 3'd7) st_nx = TX_STOP;
            TX_STOP:  if (ph_end) st_nx = TX_IDLE;
            default:  st_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd  <= 1'b1;
            ph   <= '0;
            bitn <= '0;
            sh   <= '0;
        end else if (take) begin
            sh  <= hold_data;
            txd <= 1'b0;
            ph  <= '0;
        end else if (tick && st != TX_IDLE) begin
            ph <= ph + 1'b1;
            if (ph == PH_LAST) begin
                unique case (st)
                    TX_START: begin
                        txd  <= sh[0];
                        bitn <= '0;
                    end
                    TX_DATA: begin
                        if (bitn == 3'd7) begin
                            txd <= 1'b1;
                        end else begin
                            sh   <= sh >> 1;
                            txd  <= sh[1];
                            bitn <= bitn + 1'b1;
                        end
                    end
                    default: txd <= 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/abu_rx.sv
module abu_rx
    import abu_pkg::*;
#(
    parameter int PH_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       rx_s,
    output logic       done,
    output logic [7:0] data,
    output logic       ferr
);
    localparam logic [PH_W-1:0] PH_LAST = '1;
    localparam logic [PH_W-1:0] PH_MID  = PH_W'((1 << (PH_W - 1)) - 1);

    rx_state_e       st, st_nx;
    logic [PH_W-1:0] ph;
    logic [2:0]      bitn;
    logic [7:0]      sh;
    logic            ph_end;

    assign ph_end = tick && (ph == PH_LAST);

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_IDLE:     if (tick && !rx_s) st_nx = RX_START;
            RX_START:    if (tick && ph == PH_MID) st_nx = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:     if (ph_end && bitn == 3'd7) st_nx = RX_STOP;
            RX_STOP:     if (ph_end) st_nx = rx_s ? RX_IDLE : RX_HOLD_LOW;
            RX_HOLD_LOW: if (rx_s) st_nx = RX_IDLE;
            default:     st_nx = RX_IDLE;
        endcase
        if (!en) st_nx = RX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph   <= '0;
            bitn <= '0;
            sh   <= '0;
            data <= '0;
            ferr <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st == RX_IDLE) begin
                ph   <= '0;
                bitn <= '0;
            end else if (tick) begin
                unique case (st)
                    RX_START: ph <= (ph == PH_MID) ? '0 : ph + 1'b1;
                    RX_DATA: begin
                        ph <= ph + 1'b1;
                        if (ph == PH_LAST) begin
                            sh   <= {rx_s, sh[7:1]};
                            bitn <= bitn + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        ph <= ph + 1'b1;
                        if (ph == PH_LAST) begin
                            done <= en;
                            data <= sh;
                            ferr <= !rx_s;
                        end
                    end
                    default: ph <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/abu_autobaud.sv
module abu_autobaud
    import abu_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int PH_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rx_s,
    output logic             done,
    output logic [DIV_W-1:0] div_out
);
    localparam int               CNT_W = DIV_W + PH_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W:0]   HALF = (CNT_W+1)'(1) << (PH_W - 1);
    localparam logic [DIV_W+1:0] Q_LIM = (DIV_W+2)'(1) << DIV_W;

    ab_state_e        st, st_nx;
    logic [CNT_W-1:0] cnt;
    logic [DIV_W+1:0] q;

    assign done = (st == AB_MEASURE) && rx_s;

    always_comb begin
        st_nx = st;
        unique case (st)
            AB_OFF:     if (en) st_nx = AB_ARM;
            AB_ARM:     if (rx_s) st_nx = AB_EDGE;
            AB_EDGE:    if (!rx_s) st_nx = AB_MEASURE;
            AB_MEASURE: if (rx_s) st_nx = AB_OFF;
            default:    st_nx = AB_OFF;
        endcase
        if (!en) st_nx = AB_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= AB_OFF;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (st == AB_EDGE && !rx_s) begin
            cnt <= CNT_W'(1);
        end else if (st == AB_MEASURE && !rx_s && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    // rounded low time in bit units, minus one, saturated to the divisor width
    always_comb begin
        q = (DIV_W+2)'(({1'b0, cnt} + HALF) >> PH_W);
        if (q == '0)       div_out = '0;
        else if (q > Q_LIM) div_out = '1;
        else               div_out = DIV_W'(q - 1'b1);
    end
endmodule

// File: rtl/autobaud_uart.sv
module autobaud_uart
    import abu_pkg::*;
#(
    parameter int               DIV_W     = 16,
    parameter int               PH_W      = 4,
    parameter logic [DIV_W-1:0] RESET_DIV = DIV_W'(259)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        rxd,
    output logic        txd,
    output logic        irq_tx,
    output logic        irq_rx
);
    logic             rx_m, rx_s, tick;
    logic [DIV_W-1:0] divisor, ab_div;
    logic             ab_en, ab_load, ab_done_flag;
    logic             tx_ie, rx_ie;
    logic [7:0]       tx_hold;
    logic             tx_hold_full, tx_take, tx_busy;
    logic             rx_done, rx_ferr;
    logic [7:0]       rx_byte, rx_buf;
    logic             rx_full, ovr_flag, fe_flag;
    logic             wr_data, wr_div, wr_ctrl, wr_stat, rd_data;

    assign wr_data = reg_wr && reg_addr == ADDR_DATA;
    assign wr_div  = reg_wr && reg_addr == ADDR_DIV;
    assign wr_ctrl = reg_wr && reg_addr == ADDR_CTRL;
    assign wr_stat = reg_wr && reg_addr == ADDR_STAT;
    assign rd_data = reg_rd && reg_addr == ADDR_DATA;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_m <= 1'b1;
            rx_s <= 1'b1;
        end else begin
            rx_m <= rxd;
            rx_s <= rx_m;
        end
    end

    abu_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
    );

    abu_tx #(.PH_W(PH_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .hold_full(tx_hold_full), .hold_data(tx_hold),
        .take(tx_take), .busy(tx_busy), .txd(txd)
    );

    abu_rx #(.PH_W(PH_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(!ab_en), .rx_s(rx_s),
        .done(rx_done), .data(rx_byte), .ferr(rx_ferr)
    );

    abu_autobaud #(.DIV_W(DIV_W), .PH_W(PH_W)) u_ab (
        .clk(clk), .rst_n(rst_n), .en(ab_en), .rx_s(rx_s),
        .done(ab_load), .div_out(ab_div)
    );

    // divisor and control
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            divisor <= RESET_DIV;
            ab_en   <= 1'b0;
            tx_ie   <= 1'b0;
            rx_ie   <= 1'b0;
        end else begin
            if (ab_load)     divisor <= ab_div;
            else if (wr_div) divisor <= reg_wdata[DIV_W-1:0];
            if (wr_ctrl) begin
                tx_ie <= reg_wdata[1];
                rx_ie <= reg_wdata[2];
            end
            if (ab_load)      ab_en <= 1'b0;
            else if (wr_ctrl) ab_en <= reg_wdata[0];
        end
    end

    // transmit holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_hold      <= '0;
            tx_hold_full <= 1'b0;
        end else if (tx_take) begin
            tx_hold_full <= 1'b0;
        end else if (wr_data && !tx_hold_full) begin
            tx_hold      <= reg_wdata[7:0];
            tx_hold_full <= 1'b1;
        end
    end

    // receive holding register and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf       <= '0;
            rx_full      <= 1'b0;
            ovr_flag     <= 1'b0;
            fe_flag      <= 1'b0;
            ab_done_flag <= 1'b0;
        end else begin
            if (rx_done && (!rx_full || rd_data)) begin
                rx_buf  <= rx_byte;
                rx_full <= 1'b1;
            end else if (rd_data) begin
                rx_full <= 1'b0;
            end

            if (rx_done && rx_full && !rd_data) ovr_flag <= 1'b1;
            else if (wr_stat && reg_wdata[2])   ovr_flag <= 1'b0;

            if (rx_done && rx_ferr)           fe_flag <= 1'b1;
            else if (wr_stat && reg_wdata[3]) fe_flag <= 1'b0;

            if (ab_load)                      ab_done_flag <= 1'b1;
            else if (wr_stat && reg_wdata[4]) ab_done_flag <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_DATA: reg_rdata = 16'(rx_buf);
            ADDR_DIV:  reg_rdata = 16'(divisor);
            ADDR_CTRL: reg_rdata = 16'({rx_ie, tx_ie, ab_en});
            default:   reg_rdata = 16'({!tx_busy, ab_done_flag, fe_flag,
                                        ovr_flag, rx_full, !tx_hold_full});
        endcase
    end

    assign irq_tx = tx_ie && !tx_hold_full;
    assign irq_rx = rx_ie && (rx_full || ab_done_flag);
endmodule

// File: rtl/autobaud_uart_chk.sv
module autobaud_uart_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             txd,
    input logic             tx_busy,
    input logic             tx_hold_full,
    input logic             tx_take,
    input logic [7:0]       tx_hold,
    input logic             rx_done,
    input logic             rx_full,
    input logic             ovr_flag,
    input logic             ab_en,
    input logic             ab_load,
    input logic             ab_done_flag,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [DIV_W-1:0] divisor
);
    p_idle_line_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    p_hold_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hold_full && !tx_take |=> tx_hold_full && $stable(tx_hold));

    p_full_from_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(rx_done));

    p_overrun_needs_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $past(rx_full));

    p_div_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 2'd1) && !ab_load |=> $stable(divisor));

    p_ab_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ab_done_flag) |-> !ab_en && $past(ab_en));
endmodule

bind autobaud_uart autobaud_uart_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy),
    .tx_hold_full(tx_hold_full), .tx_take(tx_take), .tx_hold(tx_hold),
    .rx_done(rx_done), .rx_full(rx_full), .ovr_flag(ovr_flag),
    .ab_en(ab_en), .ab_load(ab_load), .ab_done_flag(ab_done_flag),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .divisor(divisor)
);

// File: tb/tb_autobaud_uart.sv
module tb_autobaud_uart;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        rxd = 1'b1;
    logic        txd, irq_tx, irq_rx;

    int         n_cmp = 0, n_bad = 0;
    int         bt = 64;
    logic [7:0] exp_q[$];
    logic [15:0] r;

    always #10 clk = ~clk;

    autobaud_uart #(.DIV_W(16), .PH_W(4), .RESET_DIV(16'd3)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rxd(rxd), .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b, input bit stop_v, input int t);
        @(negedge clk);
        rxd = 1'b0;
        repeat (t) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (t) @(negedge clk);
        end
        rxd = stop_v;
        repeat (t) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * t) @(negedge clk);
    endtask

    task automatic send_tx(input logic [7:0] b);
        exp_q.push_back(b);
        wr(2'd0, {8'h00, b});
    endtask

    task automatic wait_tx_done();
        logic [15:0] s;
        do rd(2'd3, s); while (s[0] !== 1'b1 || s[5] !== 1'b1);
        repeat (bt) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // scoreboard monitor on the serial output (R2)
    initial begin
        logic [7:0] v;
        logic [7:0] e;
        wait (rst_n === 1'b1);
        forever begin
            @(negedge txd);
            repeat (bt / 2) @(negedge clk);
            check_eq("R2 start bit low", 32'(txd), 32'd0);
            for (int i = 0; i < 8; i++) begin
                repeat (bt) @(negedge clk);
                v[i] = txd;
            end
            repeat (bt) @(negedge clk);
            check_eq("R2 stop bit high", 32'(txd), 32'd1);
            if (exp_q.size() == 0) begin
                check_eq("R3 unexpected frame", 32'(v), 32'h1ff);
            end else begin
                e = exp_q.pop_front();
                check_eq("R2 tx frame data", 32'(v), 32'(e));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state, R12 idle flag
        check_eq("R1 txd idle", 32'(txd), 32'd1);
        check_eq("R1 irq_tx", 32'(irq_tx), 32'd0);
        check_eq("R1 irq_rx", 32'(irq_rx), 32'd0);
        rd(2'd1, r); check_eq("R1 divisor", 32'(r), 32'd3);
        rd(2'd2, r); check_eq("R1 control", 32'(r), 32'd0);
        rd(2'd3, r); check_eq("R1 R12 status", 32'(r), 32'h21);

        // R2 single frame
        send_tx(8'hA5);
        wait_tx_done();

        // R3 double buffer and ignored write
        send_tx(8'h3C);
        repeat (10) @(negedge clk);
        rd(2'd3, r); check_eq("R3 R12 holding empty while shifting", 32'(r), 32'h01);
        send_tx(8'h81);
        rd(2'd3, r); check_eq("R3 holding full", 32'(r), 32'h00);
        wr(2'd0, 16'h00EE);
        wait_tx_done();
        check_eq("R3 all queued frames sent", 32'(exp_q.size()), 32'd0);

        // R10 transmit interrupt
        wr(2'd2, 16'h0002);
        check_eq("R10 irq_tx enabled and empty", 32'(irq_tx), 32'd1);
        wr(2'd2, 16'h0004);
        check_eq("R10 irq_tx disabled", 32'(irq_tx), 32'd0);

        // R4 receive with R10 receive interrupt
        send_rx(8'h5A, 1'b1, bt);
        check_eq("R10 irq_rx on full", 32'(irq_rx), 32'd1);
        rd(2'd3, r); check_eq("R4 status full", 32'(r), 32'h23);
        rd(2'd0, r); check_eq("R4 rx data", 32'(r), 32'h5A);
        rd(2'd3, r); check_eq("R4 status after read", 32'(r), 32'h21);
        check_eq("R10 irq_rx cleared", 32'(irq_rx), 32'd0);

        // R5 framing error
        send_rx(8'h33, 1'b0, bt);
        rd(2'd3, r); check_eq("R5 framing flag", 32'(r), 32'h2B);
        rd(2'd0, r); check_eq("R5 data kept", 32'(r), 32'h33);
        wr(2'd3, 16'h0008);
        rd(2'd3, r); check_eq("R5 flag cleared", 32'(r), 32'h21);

        // R6 overrun
        send_rx(8'h11, 1'b1, bt);
        send_rx(8'h22, 1'b1, bt);
        rd(2'd3, r); check_eq("R6 overrun flag", 32'(r), 32'h27);
        rd(2'd0, r); check_eq("R6 first char kept", 32'(r), 32'h11);
        wr(2'd3, 16'h0004);
        rd(2'd3, r); check_eq("R6 flag cleared", 32'(r), 32'h21);

        // R7 full duplex
        fork
            send_tx(8'h96);
            send_rx(8'h69, 1'b1, bt);
        join
        wait_tx_done();
        rd(2'd0, r); check_eq("R7 rx during tx", 32'(r), 32'h69);
        check_eq("R7 tx during rx", 32'(exp_q.size()), 32'd0);

        // R8 divisor write, R11 top rate
        wr(2'd1, 16'h0000);
        rd(2'd1, r); check_eq("R8 divisor readback", 32'(r), 32'd0);
        bt = 16;
        send_tx(8'hC3);
        wait_tx_done();
        send_rx(8'hE7, 1'b1, bt);
        rd(2'd0, r); check_eq("R11 rx at top rate", 32'(r), 32'hE7);

        // R9 auto-rate detection
        wr(2'd2, 16'h0005);
        repeat (4) @(negedge clk);
        send_rx(8'hFF, 1'b1, 96);
        rd(2'd2, r); check_eq("R9 mode left", 32'(r), 32'h4);
        rd(2'd1, r); check_eq("R9 divisor loaded", 32'(r), 32'd5);
        rd(2'd3, r); check_eq("R9 done flag, nothing received", 32'(r), 32'h31);
        check_eq("R10 irq_rx on done", 32'(irq_rx), 32'd1);
        wr(2'd3, 16'h0010);
        rd(2'd3, r); check_eq("R9 done cleared", 32'(r), 32'h21);
        bt = 96;
        send_rx(8'h4B, 1'b1, bt);
        rd(2'd0, r); check_eq("R9 R8 rx at detected rate", 32'(r), 32'h4B);
        send_tx(8'h2D);
        wait_tx_done();
        check_eq("R9 R8 tx at detected rate", 32'(exp_q.size()), 32'd0);

        finish_run();
    end
endmodule